// File: doc/BRIEF.md
# Self-Timed Program Engine with Write Protect

This block sits behind the serial command decoder of a small nonvolatile memory model. The decoder hands it one complete command at a time, and the command is one of these: enable writes, disable writes, erase one location, write one location, erase everything, or write everything. The block keeps a write-enable latch that software must set before any change to the array is allowed. A program command that is accepted only waits at first. The timed cycle begins on the first select falling-edge strobe after it. The cycle then drives a write port into a register-array memory. A write first fills its target with ones and then stores the data. The cycle holds busy for a parameterised number of system ticks, so no serial clock is needed while it runs.

The array is organised as words of `NLANE` byte lanes. In wide mode each command addresses one word. In byte mode the command address also picks one lane, the byte is copied onto every lane, and the byte enables select the lane that is written. While the select line is high after a cycle has started, the block presents a registered status bit: low means busy and high means ready. The front end can hide this status by shifting in a one on a clock rising edge.

Top module: `prog_engine`

## Requirements
- R1: After reset `busy`, `mem_we` and `status_oe` are low and the write-enable latch is cleared.
- R2: `cmd_op` = 1 sets the latch and `cmd_op` = 2 clears it. A program command (codes 3 to 6) received while the latch is clear causes no array write and no busy cycle.
- R3: An accepted program command starts a cycle only on a later `cs_fall` strobe. A `cs_fall` with nothing pending does nothing. Any other command, including code 0 (no program, e.g. a read), cancels a pending one.
- R4: Erase (code 3) makes exactly one write of all ones to the target.
- R5: Write (code 4) makes one all-ones write and then one data write, both to the same word and lanes.
- R6: Erase-all (code 5) writes all ones to every word in ascending order with all lanes enabled.
- R7: Write-all (code 6) first clears every word in ascending order and then stores the data word into every word in ascending order.
- R8: With `org_wide` = 1 the word is `cmd_addr[WORD_AW-1:0]`, `mem_be` is all ones and the data is `cmd_data`. With `org_wide` = 0 the word is `cmd_addr` shifted right by log2(NLANE), and the lane is the low address bits: lane k is `mem_wdata[8k+7:8k]` and `mem_be[k]`. The low byte of `cmd_data` is copied onto every lane. All-location operations always enable every lane.
- R9: `busy` rises on the clock after the starting `cs_fall`. It stays high until all writes of the cycle are done and at least `CYCLE_TICKS` ticks have passed.
- R10: Commands of every code received while `busy` is high are ignored, including latch changes.
- R11: Once a cycle has started, `status_oe` follows `cs_high` one clock later, and `status_val` is the inverse of `busy` one clock later.
- R12: A `sk_rise` with `di` = 1 while `cs_high` is set drops `status_oe` on the next clock. It stays low until the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | System time-base strobe |
| cmd_valid | input | 1 | Complete command present |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | WORD_AW+log2(NLANE) | Command address |
| cmd_data | input | BW*NLANE | Command data |
| org_wide | input | 1 | 1 = word organisation, 0 = byte |
| cs_fall | input | 1 | Select falling-edge strobe |
| cs_high | input | 1 | Select level |
| sk_rise | input | 1 | Serial clock rising-edge strobe |
| di | input | 1 | Serial data input level |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | WORD_AW | Array word address |
| mem_be | output | NLANE | Array lane enables |
| mem_wdata | output | BW*NLANE | Array write data |
| busy | output | 1 | Program cycle running |
| status_oe | output | 1 | Drive status on serial output |
| status_val | output | 1 | Status level, 1 = ready |

## Verification
The bench aims at the latch gate first. Both at power-up and after a disable command, it checks that a program request with the latch clear leaves the array port silent, because a design that ignored the latch would corrupt memory. It cancels a pending write with another command, strobes a select falling edge with nothing pending, and sends commands during busy. A faulty engine would start a stray cycle or lose the enable latch in those cases. It compares every write-port beat against queued expectations: clear-before-store order, byte-lane mapping in byte mode, and full ascending sweeps. It also checks that busy covers the tick window and every sweep beat, and that the status output hides on a shifted-in one.

// File: rtl/prog_pkg.sv
package prog_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_ENABLE    = 3'd1,
    OP_DISABLE   = 3'd2,
    OP_ERASE     = 3'd3,
    OP_WRITE     = 3'd4,
    OP_ERASE_ALL = 3'd5,
    OP_WRITE_ALL = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_STORE = 2'd2,
    PH_WAIT  = 2'd3
  } phase_e;

  function automatic logic is_program(op_e op);
    return (op == OP_ERASE) || (op == OP_WRITE) ||
           (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
  endfunction

endpackage

// File: rtl/prog_wel.sv
module prog_wel
  import prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       busy,
  output logic       wel
);
  op_e op;
  assign op = op_e'(cmd_op);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
    end else if (cmd_valid && !busy) begin
      if (op == OP_ENABLE)       wel <= 1'b1;
      else if (op == OP_DISABLE) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/prog_decode.sv
module prog_decode
  import prog_pkg::*;
#(
  parameter int WORD_AW = 8,
  parameter int BW      = 8,
  parameter int NLANE   = 2
) (
  input  logic [2:0]                        cmd_op,
  input  logic [WORD_AW+$clog2(NLANE)-1:0]  cmd_addr,
  input  logic [BW*NLANE-1:0]               cmd_data,
  input  logic                              org_wide,
  output logic                              is_prog,
  output logic                              is_all,
  output logic                              has_store,
  output logic [WORD_AW-1:0]                word,
  output logic [NLANE-1:0]                  be,
  output logic [BW*NLANE-1:0]               data
);
  localparam int LANE_W = $clog2(NLANE);
  localparam int DW     = BW * NLANE;

  op_e op;
  assign op        = op_e'(cmd_op);
  assign is_prog   = is_program(op);
  assign is_all    = (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
  assign has_store = (op == OP_WRITE) || (op == OP_WRITE_ALL);

  logic [LANE_W-1:0] lane;
  assign lane = cmd_addr[LANE_W-1:0];

  logic [DW-1:0] byte_rep;
  for (genvar k = 0; k < NLANE; k++) begin : g_rep
    assign byte_rep[k*BW +: BW] = cmd_data[BW-1:0];
  end

  always_comb begin
    if (org_wide) begin
      word = cmd_addr[WORD_AW-1:0];
      be   = '1;
      data = cmd_data;
    end else begin
      word = cmd_addr[WORD_AW+LANE_W-1:LANE_W];
      be   = '0;
      be[lane] = 1'b1;
      data = byte_rep;
    end
    if (is_all) be = '1;
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_pkg::*;
#(
  parameter int WORD_AW     = 8,
  parameter int BW          = 8,
  parameter int NLANE       = 2,
  parameter int CYCLE_TICKS = 5000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  cmd_valid,
  input  logic                  wel,
  input  logic                  d_prog,
  input  logic                  d_all,
  input  logic                  d_store,
  input  logic [WORD_AW-1:0]    d_word,
  input  logic [NLANE-1:0]      d_be,
  input  logic [BW*NLANE-1:0]   d_data,
  input  logic                  cs_fall,
  output logic                  busy,
  output logic                  start,
  output logic                  mem_we,
  output logic [WORD_AW-1:0]    mem_addr,
  output logic [NLANE-1:0]      mem_be,
  output logic [BW*NLANE-1:0]   mem_wdata
);
  localparam int DW    = BW * NLANE;
  localparam int DEPTH = 1 << WORD_AW;
  localparam int TCW   = $clog2(CYCLE_TICKS + 1);
  localparam logic [WORD_AW-1:0] LAST_W = WORD_AW'(DEPTH - 1);
  localparam logic [TCW-1:0]     TLIM   = TCW'(CYCLE_TICKS);

  phase_e               st;
  logic                 pend_v, pend_all, pend_store;
  logic [WORD_AW-1:0]   pend_word, widx;
  logic [NLANE-1:0]     pend_be;
  logic [DW-1:0]        pend_data;
  logic [TCW-1:0]       tcnt;
  logic                 last;

  assign busy  = (st != PH_IDLE);
  assign start = cs_fall && pend_v && !busy;
  assign last  = pend_all ? (widx == LAST_W) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      pend_v     <= 1'b0;
      pend_all   <= 1'b0;
      pend_store <= 1'b0;
      pend_word  <= '0;
      pend_be    <= '0;
      pend_data  <= '0;
      widx       <= '0;
      tcnt       <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy && tick && (tcnt != TLIM)) tcnt <= tcnt + 1'b1;
      unique case (st)
        PH_IDLE: begin
          if (start) begin
            st     <= PH_CLEAR;
            pend_v <= 1'b0;
            widx   <= '0;
            tcnt   <= '0;
          end else if (cmd_valid) begin
            pend_v     <= d_prog && wel;
            pend_all   <= d_all;
            pend_store <= d_store;
            pend_word  <= d_word;
            pend_be    <= d_be;
            pend_data  <= d_data;
          end
        end
        PH_CLEAR, PH_STORE: begin
          mem_we    <= 1'b1;
          mem_addr  <= pend_all ? widx : pend_word;
          mem_be    <= pend_be;
          mem_wdata <= (st == PH_CLEAR) ? {DW{1'b1}} : pend_data;
          if (last) begin
            widx <= '0;
            st   <= (st == PH_CLEAR && pend_store) ? PH_STORE : PH_WAIT;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        PH_WAIT: begin
          if (tcnt == TLIM) st <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prog_status.sv
module prog_status (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cmd_valid,
  input  logic busy,
  input  logic cs_high,
  input  logic sk_rise,
  input  logic di,
  output logic status_oe,
  output logic status_val
);
  logic shown, dismiss;
  assign dismiss = cs_high && sk_rise && di;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown      <= 1'b0;
      status_oe  <= 1'b0;
      status_val <= 1'b1;
    end else begin
      if (start)                     shown <= 1'b1;
      else if (dismiss || (cmd_valid && !busy)) shown <= 1'b0;
      status_oe  <= cs_high && shown && !dismiss;
      status_val <= !busy;
    end
  end
endmodule

// File: rtl/prog_engine.sv
module prog_engine
  import prog_pkg::*;
#(
  parameter int WORD_AW     = 8,
  parameter int BW          = 8,
  parameter int NLANE       = 2,
  parameter int CYCLE_TICKS = 5000
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             tick,
  input  logic                             cmd_valid,
  input  logic [2:0]                       cmd_op,
  input  logic [WORD_AW+$clog2(NLANE)-1:0] cmd_addr,
  input  logic [BW*NLANE-1:0]              cmd_data,
  input  logic                             org_wide,
  input  logic                             cs_fall,
  input  logic                             cs_high,
  input  logic                             sk_rise,
  input  logic                             di,
  output logic                             mem_we,
  output logic [WORD_AW-1:0]               mem_addr,
  output logic [NLANE-1:0]                 mem_be,
  output logic [BW*NLANE-1:0]              mem_wdata,
  output logic                             busy,
  output logic                             status_oe,
  output logic                             status_val
);
  logic                 wel, start;
  logic                 d_prog, d_all, d_store;
  logic [WORD_AW-1:0]   d_word;
  logic [NLANE-1:0]     d_be;
  logic [BW*NLANE-1:0]  d_data;

  prog_wel wel_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .wel(wel)
  );

  prog_decode #(.WORD_AW(WORD_AW), .BW(BW), .NLANE(NLANE)) dec_i (
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .org_wide(org_wide), .is_prog(d_prog), .is_all(d_all),
    .has_store(d_store), .word(d_word), .be(d_be), .data(d_data)
  );

  prog_seq #(.WORD_AW(WORD_AW), .BW(BW), .NLANE(NLANE),
             .CYCLE_TICKS(CYCLE_TICKS)) seq_i (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .wel(wel),
    .d_prog(d_prog), .d_all(d_all), .d_store(d_store), .d_word(d_word),
    .d_be(d_be), .d_data(d_data), .cs_fall(cs_fall), .busy(busy),
    .start(start), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  prog_status stat_i (
    .clk(clk), .rst(rst), .start(start), .cmd_valid(cmd_valid),
    .busy(busy), .cs_high(cs_high), .sk_rise(sk_rise), .di(di),
    .status_oe(status_oe), .status_val(status_val)
  );
endmodule

// File: rtl/prog_engine_chk.sv
module prog_engine_chk #(
  parameter int CYCLE_TICKS = 5000
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic cs_fall,
  input logic cs_high,
  input logic mem_we,
  input logic busy,
  input logic status_oe,
  input logic wel
);
  localparam int TCW = $clog2(CYCLE_TICKS + 1);
  localparam logic [TCW-1:0] TLIM = TCW'(CYCLE_TICKS);

  logic [TCW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst || !busy)                 seen <= '0;
    else if (tick && (seen != TLIM))  seen <= seen + 1'b1;
  end

  // R2: the array is only touched inside a program cycle
  a_r2_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R2: a cycle only begins with the latch set
  a_r2_latch_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  // R3: a cycle only begins after a select falling strobe
  a_r3_start_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_fall));

  // R9: busy covers the full tick window
  a_r9_min_window: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (seen >= TLIM));

  // R10: the latch does not move during a cycle
  a_r10_latch_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wel));

  // R11: status is never driven while deselected
  a_r11_hidden_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_high |=> !status_oe);
endmodule

bind prog_engine prog_engine_chk #(.CYCLE_TICKS(CYCLE_TICKS)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .cs_fall(cs_fall), .cs_high(cs_high),
  .mem_we(mem_we), .busy(busy), .status_oe(status_oe), .wel(wel)
);

// File: tb/prog_engine_tb_top.sv
module prog_engine_tb_top;
  localparam int WORD_AW = 8;
  localparam int BW = 8;
  localparam int NLANE = 2;
  localparam int CT = 20;
  localparam int TDIV = 4;
  localparam int DEPTH = 1 << WORD_AW;

  logic clk = 0, rst = 1, tick = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [8:0] cmd_addr = 0;
  logic [15:0] cmd_data = 0;
  logic org_wide = 1, cs_fall = 0, cs_high = 0, sk_rise = 0, di = 0;
  logic mem_we;
  logic [7:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata;
  logic busy, status_oe, status_val;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  int tdiv_cnt = 0;
  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
    tick <= (tdiv_cnt == TDIV-1);
  end

  prog_engine #(.WORD_AW(WORD_AW), .BW(BW), .NLANE(NLANE), .CYCLE_TICKS(CT)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .org_wide(org_wide),
    .cs_fall(cs_fall), .cs_high(cs_high), .sk_rise(sk_rise), .di(di),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .busy(busy), .status_oe(status_oe), .status_val(status_val)
  );

  typedef struct {
    logic [7:0]  a;
    logic [1:0]  be;
    logic [15:0] d;
    string       tag;
  } beat_t;
  beat_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d, input string tag);
    beat_t b;
    b.a = a; b.be = be; b.d = d; b.tag = tag;
    exp_q.push_back(b);
  endtask

  // monitor: compare each array beat against the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected array write", {14'd0, mem_be, mem_addr, 8'd0}, 0);
      end else begin
        beat_t b;
        b = exp_q.pop_front();
        check(mem_addr == b.a, {b.tag, " addr"}, mem_addr, b.a);
        check(mem_be == b.be, {b.tag, " lanes"}, mem_be, b.be);
        check(mem_wdata == b.d, {b.tag, " data"}, mem_wdata, b.d);
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic fall();
    @(negedge clk);
    cs_fall = 1;
    @(negedge clk);
    cs_fall = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input string tag);
    repeat (10) @(negedge clk);
    check(busy == 0, tag, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(mem_we == 0, "R1 write strobe", mem_we, 0);
    check(status_oe == 0, "R1 status hidden", status_oe, 0);

    // R1/R2: latch clear after reset blocks a write
    send(3'd4, 9'd3, 16'h1234);
    fall();
    quiet("R2 write with latch clear after R1 reset");

    // R4 erase, R9 busy timing, R11 status
    send(3'd1, 0, 0);
    send(3'd3, 9'd5, 0);
    push(8'd5, 2'b11, 16'hFFFF, "R4 erase");
    fall();
    check(busy == 1, "R9 busy after strobe", busy, 1);
    cs_high = 1;
    repeat (3) @(negedge clk);
    check(status_oe == 1, "R11 status shown", status_oe, 1);
    check(status_val == 0, "R11 status busy", status_val, 0);
    wait_idle(n);
    check(n >= (CT-2)*TDIV, "R9 busy window", n, (CT-2)*TDIV);
    repeat (2) @(negedge clk);
    check(status_val == 1, "R11 status ready", status_val, 1);
    check(exp_q.size() == 0, "R4 beats done", exp_q.size(), 0);
    // R12 dismiss
    sk_rise = 1; di = 1;
    @(negedge clk);
    sk_rise = 0; di = 0;
    check(status_oe == 0, "R12 dismissed", status_oe, 1'b0);
    repeat (3) @(negedge clk);
    check(status_oe == 0, "R12 stays hidden", status_oe, 1'b0);
    cs_high = 0;

    // R3: the cycle waits for the strobe
    send(3'd4, 9'd7, 16'hA5C3);
    quiet("R3 no cycle before strobe");
    push(8'd7, 2'b11, 16'hFFFF, "R5 clear");
    push(8'd7, 2'b11, 16'hA5C3, "R5 store");
    fall();
    wait_idle(n);
    check(exp_q.size() == 0, "R5 beats done", exp_q.size(), 0);

    // R3: a strobe with nothing pending, then a cancelled command
    fall();
    quiet("R3 lone strobe");
    send(3'd4, 9'd9, 16'h1111);
    send(3'd0, 0, 0);
    fall();
    quiet("R3 cancelled write");

    // R8 byte mode
    org_wide = 0;
    send(3'd4, 9'h00B, 16'h005A);
    push(8'd5, 2'b10, 16'hFFFF, "R8 byte clear");
    push(8'd5, 2'b10, 16'h5A5A, "R8 byte store");
    fall();
    wait_idle(n);
    send(3'd3, 9'h00C, 0);
    push(8'd6, 2'b01, 16'hFFFF, "R8 byte erase");
    fall();
    wait_idle(n);
    check(exp_q.size() == 0, "R8 beats done", exp_q.size(), 0);
    org_wide = 1;

    // R10: commands while busy are ignored
    send(3'd4, 9'd1, 16'hBEEF);
    push(8'd1, 2'b11, 16'hFFFF, "R10 clear");
    push(8'd1, 2'b11, 16'hBEEF, "R10 store");
    fall();
    send(3'd2, 0, 0);
    send(3'd4, 9'd2, 16'h2222);
    wait_idle(n);
    fall();
    quiet("R10 command during busy dropped");
    send(3'd3, 9'd4, 0);
    push(8'd4, 2'b11, 16'hFFFF, "R10 latch kept");
    fall();
    wait_idle(n);
    check(exp_q.size() == 0, "R10 beats done", exp_q.size(), 0);

    // R6 erase-all
    send(3'd5, 0, 0);
    for (int i = 0; i < DEPTH; i++) push(8'(i), 2'b11, 16'hFFFF, "R6 erase sweep");
    fall();
    wait_idle(n);
    check(exp_q.size() == 0, "R6 sweep done before ready", exp_q.size(), 0);

    // R7 write-all, wide then byte mode
    send(3'd6, 0, 16'h0F0F);
    for (int i = 0; i < DEPTH; i++) push(8'(i), 2'b11, 16'hFFFF, "R7 clear sweep");
    for (int i = 0; i < DEPTH; i++) push(8'(i), 2'b11, 16'h0F0F, "R7 store sweep");
    fall();
    wait_idle(n);
    check(exp_q.size() == 0, "R7 sweep done before ready", exp_q.size(), 0);
    org_wide = 0;
    send(3'd6, 9'd3, 16'h003C);
    for (int i = 0; i < DEPTH; i++) push(8'(i), 2'b11, 16'hFFFF, "R8 all clear");
    for (int i = 0; i < DEPTH; i++) push(8'(i), 2'b11, 16'h3C3C, "R8 all store");
    fall();
    wait_idle(n);
    check(exp_q.size() == 0, "R8 all done", exp_q.size(), 0);
    org_wide = 1;

    // R2: disable blocks erase-all
    send(3'd2, 0, 0);
    send(3'd5, 0, 0);
    fall();
    quiet("R2 erase-all after disable");
    check(exp_q.size() == 0, "R2 queue empty", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule